// File: doc/BRIEF.md
# SD Command Line Engine

This block issues one SD card command at a time on the single-bit CMD line and collects the card's reply. Software loads a 32-bit argument and then writes a 16-bit command word whose top bit starts the command. The engine sends a 48-bit command frame that carries its own CRC7. It then waits for a 48-bit reply, a 136-bit reply, or no reply at all. It stores the reply in four 32-bit response words. It flags a missing reply or a bad reply checksum. It can also hold the command open until the card releases DAT0 after a busy period.

Bit timing comes from a free-running tick, one pulse every `TICK_DIV` system clocks. The same tick clocks both directions: at each tick edge the engine drives its next outgoing bit and samples `cmd_i`. The wide data bus, any data buffering and card power switching belong elsewhere.

Register word addresses on `reg_addr`: 0 command word, 1 argument, 2 reply timeout (reset value 64), 3 status, 4 to 7 response words 0 to 3.

Top module: `sdc_cmd_engine`

## Requirements
- R1: After a launch the engine drives `cmd_oe` high for exactly 48 consecutive bit ticks. It sends, MSB first, a `0`, a `1`, the 6-bit index, the 32-bit argument, a CRC7 (polynomial x^7+x^3+1, zero seed) over those first 40 bits, and a closing `1`.
- R2: Command word bit 15 launches a command when written as 1. It reads back as 1 while the command is in flight and returns to 0 once the command completes.
- R3: A command word write made while a command is in flight is ignored: no second frame goes out and the stored command word is unchanged.
- R4: A short reply is 48 bits long and begins with a `0` start bit. Response word 0 receives reply bits 39:8, and response words 1 to 3 are cleared.
- R5: With command word bit 9 set, a 136-bit reply is received. Response words 0 to 3 receive reply bits 31:0, 63:32, 95:64 and 127:96, and no checksum is checked.
- R6: The engine counts the CMD samples taken after the frame. If the start bit does not arrive within the number of samples set in the timeout register, status bit 6 and command word bit 14 are set and the response words are left unchanged. A start bit arriving exactly on the last allowed sample is accepted.
- R7: When the CRC7 of a short reply's bits 47:8 does not match its bits 7:1, status bit 4 and command word bit 14 are set. The reply is still stored.
- R8: With command word bit 10 set, the command completes right after the frame, with no reply wait and no error, even if bit 9 is also set.
- R9: With command word bit 11 set and a short reply, completion waits until `dat0_i` is sampled high, and status bit 10 is then set. When bit 9 is also set, bit 11 is ignored.
- R10: Writing a 1 to a status bit clears it, and writing a 0 leaves it alone.
- R11: A command word write accepted while idle stores bits 11, 10, 9, 7, 6 and 5:0 so that they read back unchanged, and it clears bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| bit_stb | output | 1 | Bit tick: the line moves one bit at each clock edge where this is high |
| cmd_o | output | 1 | CMD line value driven by the host |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_i | input | 1 | CMD line value from the card |
| dat0_i | input | 1 | DAT0 from the card, low while busy |

## Verification
Each outgoing bit appears one clock after the tick edge that drives it. The bench's card model therefore reads `cmd_o` and updates `cmd_i` and `dat0_i` only on falling clock edges inside a tick cycle, so every exchange lines up with the engine's sampling edge. A result is in the registers one clock after the engine's final sampling edge, in the same cycle that bit 15 falls. The bench polls bit 15 and reads the response and status registers only after it has seen bit 15 clear. Timing claims are checked with cycle stamps: the no-reply completion must land within a fixed window after launch, and a busy completion must come after the DAT0 release (or before it when the busy request is ignored).

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int FRAME_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int RSP_WORDS  = 4;
    localparam int ADDR_W     = 3;

    localparam logic [ADDR_W-1:0] A_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] A_ARG  = 3'd1;
    localparam logic [ADDR_W-1:0] A_TOUT = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd3;

    localparam int CW_START = 15;
    localparam int CW_FAIL  = 14;
    localparam int CW_BUSY  = 11;
    localparam int CW_NORSP = 10;
    localparam int CW_LONG  = 9;
    localparam int CW_WRD   = 7;
    localparam int CW_RDD   = 6;

    localparam int ST_BUSYDONE = 10;
    localparam int ST_TOUT     = 6;
    localparam int ST_CRC      = 4;

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
        logic        no_rsp;
        logic        long_rsp;
        logic        busy_wait;
    } cmd_req_t;

    typedef struct packed {
        logic         timeout;
        logic         crc_bad;
        logic         busy_done;
        logic         got_rsp;
        logic [127:0] words;
    } cmd_res_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEND,
        S_WAIT,
        S_RECV,
        S_BUSY
    } seq_state_e;

    function automatic logic [6:0] crc7_calc(input logic [39:0] d);
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = 39; i >= 0; i--) begin
            fb = d[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [FRAME_BITS-1:0] make_frame(input cmd_req_t r);
        logic [39:0] head;
        head = {2'b01, r.idx, r.arg};
        return {head, crc7_calc(head), 1'b1};
    endfunction

endpackage

// File: rtl/sdc_tick_gen.sv
module sdc_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic stb
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            stb <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt <= '0;
            stb <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
            stb <= 1'b0;
        end
    end
endmodule

// File: rtl/sdc_regs.sv
module sdc_regs
    import sdc_pkg::*;
#(
    parameter logic [31:0] TOUT_RESET = 32'd64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              go,
    output cmd_req_t          req,
    output logic [31:0]       tout_val,
    input  logic              fin,
    input  cmd_res_t          res
);
    logic        start_q, fail_q;
    logic [5:0]  idx_q;
    logic        rdd_q, wrd_q, long_q, norsp_q, busy_q;
    logic [31:0] arg_q, tout_q;
    logic        st_busy_q, st_tout_q, st_crc_q;
    logic [31:0] rsp_q [RSP_WORDS];

    logic cmd_wr, stat_wr;
    assign cmd_wr  = wr && (addr == A_CMD) && !start_q;
    assign stat_wr = wr && (addr == A_STAT);
    assign go      = cmd_wr && wdata[CW_START];

    always_comb begin
        req.idx       = wdata[5:0];
        req.arg       = arg_q;
        req.no_rsp    = wdata[CW_NORSP];
        req.long_rsp  = wdata[CW_LONG];
        req.busy_wait = wdata[CW_BUSY];
    end

    assign tout_val = tout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q   <= 1'b0;
            fail_q    <= 1'b0;
            idx_q     <= '0;
            rdd_q     <= 1'b0;
            wrd_q     <= 1'b0;
            long_q    <= 1'b0;
            norsp_q   <= 1'b0;
            busy_q    <= 1'b0;
            arg_q     <= '0;
            tout_q    <= TOUT_RESET;
            st_busy_q <= 1'b0;
            st_tout_q <= 1'b0;
            st_crc_q  <= 1'b0;
            for (int i = 0; i < RSP_WORDS; i++) rsp_q[i] <= '0;
        end else begin
            if (cmd_wr) begin
                start_q <= wdata[CW_START];
                fail_q  <= 1'b0;
                idx_q   <= wdata[5:0];
                rdd_q   <= wdata[CW_RDD];
                wrd_q   <= wdata[CW_WRD];
                long_q  <= wdata[CW_LONG];
                norsp_q <= wdata[CW_NORSP];
                busy_q  <= wdata[CW_BUSY];
            end
            if (wr && addr == A_ARG)  arg_q  <= wdata;
            if (wr && addr == A_TOUT) tout_q <= wdata;
            if (stat_wr) begin
                if (wdata[ST_BUSYDONE]) st_busy_q <= 1'b0;
                if (wdata[ST_TOUT])     st_tout_q <= 1'b0;
                if (wdata[ST_CRC])      st_crc_q  <= 1'b0;
            end
            if (fin) begin
                start_q <= 1'b0;
                fail_q  <= res.timeout | res.crc_bad;
                if (res.busy_done) st_busy_q <= 1'b1;
                if (res.timeout)   st_tout_q <= 1'b1;
                if (res.crc_bad)   st_crc_q  <= 1'b1;
                if (res.got_rsp)
                    for (int i = 0; i < RSP_WORDS; i++)
                        rsp_q[i] <= res.words[32*i +: 32];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr[2]) begin
            rdata = rsp_q[addr[1:0]];
        end else begin
            case (addr)
                A_CMD:  rdata = {16'b0, start_q, fail_q, 2'b00, busy_q, norsp_q,
                                 long_q, 1'b0, wrd_q, rdd_q, idx_q};
                A_ARG:  rdata = arg_q;
                A_TOUT: rdata = tout_q;
                A_STAT: begin
                    rdata[ST_BUSYDONE] = st_busy_q;
                    rdata[ST_TOUT]     = st_tout_q;
                    rdata[ST_CRC]      = st_crc_q;
                end
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sdc_seq.sv
module sdc_seq
    import sdc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        stb,
    input  logic        go,
    input  cmd_req_t    req,
    input  logic [31:0] tout_val,
    input  logic        cmd_i,
    input  logic        dat0_i,
    output logic        cmd_o,
    output logic        cmd_oe,
    output logic        fin,
    output cmd_res_t    res
);
    localparam int BW = $clog2(LONG_BITS + 1);

    seq_state_e            state;
    logic [FRAME_BITS-1:0] frame;
    logic [BW-1:0]         bcnt;
    logic [31:0]           wcnt;
    logic [LONG_BITS-1:0]  rx;
    logic                  norsp_q, long_q, busy_q;

    logic [LONG_BITS-1:0]  rx_nx;
    logic                  crc_bad;
    logic [BW-1:0]         last_bit;
    logic [32:0]           wnext;

    assign rx_nx    = {rx[LONG_BITS-2:0], cmd_i};
    assign crc_bad  = !long_q && (crc7_calc(rx_nx[47:8]) != rx_nx[7:1]);
    assign last_bit = long_q ? BW'(LONG_BITS - 1) : BW'(FRAME_BITS - 1);
    assign wnext    = {1'b0, wcnt} + 33'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            frame   <= '0;
            bcnt    <= '0;
            wcnt    <= '0;
            rx      <= '0;
            norsp_q <= 1'b0;
            long_q  <= 1'b0;
            busy_q  <= 1'b0;
            cmd_o   <= 1'b1;
            cmd_oe  <= 1'b0;
            fin     <= 1'b0;
            res     <= '0;
        end else begin
            fin <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (go) begin
                        frame   <= make_frame(req);
                        bcnt    <= '0;
                        norsp_q <= req.no_rsp;
                        long_q  <= req.long_rsp;
                        busy_q  <= req.busy_wait && !req.long_rsp;
                        res     <= '0;
                        state   <= S_SEND;
                    end
                end
                S_SEND: begin
                    if (stb) begin
                        if (bcnt == BW'(FRAME_BITS)) begin
                            cmd_oe <= 1'b0;
                            cmd_o  <= 1'b1;
                            wcnt   <= '0;
                            if (norsp_q) begin
                                fin   <= 1'b1;
                                state <= S_IDLE;
                            end else begin
                                state <= S_WAIT;
                            end
                        end else begin
                            cmd_oe <= 1'b1;
                            cmd_o  <= frame[FRAME_BITS-1];
                            frame  <= {frame[FRAME_BITS-2:0], 1'b0};
                            bcnt   <= bcnt + 1'b1;
                        end
                    end
                end
                S_WAIT: begin
                    if (stb) begin
                        if (!cmd_i) begin
                            rx    <= '0;
                            bcnt  <= BW'(1);
                            state <= S_RECV;
                        end else begin
                            wcnt <= wnext[31:0];
                            if (wnext >= {1'b0, tout_val}) begin
                                res.timeout <= 1'b1;
                                fin         <= 1'b1;
                                state       <= S_IDLE;
                            end
                        end
                    end
                end
                S_RECV: begin
                    if (stb) begin
                        rx   <= rx_nx;
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == last_bit) begin
                            res.got_rsp <= 1'b1;
                            res.crc_bad <= crc_bad;
                            res.words   <= long_q ? rx_nx[127:0]
                                                  : {96'b0, rx_nx[39:8]};
                            if (busy_q && !crc_bad) begin
                                state <= S_BUSY;
                            end else begin
                                fin   <= 1'b1;
                                state <= S_IDLE;
                            end
                        end
                    end
                end
                S_BUSY: begin
                    if (stb && dat0_i) begin
                        res.busy_done <= 1'b1;
                        fin           <= 1'b1;
                        state         <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
    import sdc_pkg::*;
#(
    parameter int          TICK_DIV   = 4,
    parameter logic [31:0] TOUT_RESET = 32'd64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              bit_stb,
    output logic              cmd_o,
    output logic              cmd_oe,
    input  logic              cmd_i,
    input  logic              dat0_i
);
    logic        go;
    cmd_req_t    req;
    logic [31:0] tout_val;
    logic        fin;
    cmd_res_t    res;

    sdc_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .stb (bit_stb)
    );

    sdc_regs #(.TOUT_RESET(TOUT_RESET)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .go       (go),
        .req      (req),
        .tout_val (tout_val),
        .fin      (fin),
        .res      (res)
    );

    sdc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .stb      (bit_stb),
        .go       (go),
        .req      (req),
        .tout_val (tout_val),
        .cmd_i    (cmd_i),
        .dat0_i   (dat0_i),
        .cmd_o    (cmd_o),
        .cmd_oe   (cmd_oe),
        .fin      (fin),
        .res      (res)
    );
endmodule

// File: rtl/sdc_cmd_engine_chk.sv
module sdc_cmd_engine_chk
    import sdc_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     bit_stb,
    input logic     cmd_o,
    input logic     cmd_oe,
    input logic     dat0_i,
    input logic     go,
    input logic     fin,
    input cmd_res_t res
);
    // R1: the line only moves on a tick edge
    a_r1_line_steady: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |=> ($stable(cmd_o) && $stable(cmd_oe)));

    // R3: no launch is passed on while a frame is on the line
    a_r3_no_launch_on_line: assert property (@(posedge clk) disable iff (rst)
        cmd_oe |-> !go);

    // R2: completion is a single-cycle event
    a_r2_fin_pulse: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin);

    // R6 / R7: a reply is either missing or checked, never both
    a_r6_single_cause: assert property (@(posedge clk) disable iff (rst)
        fin |-> !(res.timeout && res.crc_bad));

    // R9: busy completion follows a high DAT0 sample on a clean reply
    a_r9_busy_after_release: assert property (@(posedge clk) disable iff (rst)
        (fin && res.busy_done) |-> ($past(dat0_i) && !res.timeout && !res.crc_bad));
endmodule

bind sdc_cmd_engine sdc_cmd_engine_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .bit_stb (bit_stb),
    .cmd_o   (cmd_o),
    .cmd_oe  (cmd_oe),
    .dat0_i  (dat0_i),
    .go      (go),
    .fin     (fin),
    .res     (res)
);

// File: tb/sdc_cmd_engine_tb.sv
module sdc_cmd_engine_tb;
    localparam int DIV  = 4;
    localparam int TOUT = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bit_stb, cmd_o, cmd_oe;
    logic        cmd_i = 1'b1;
    logic        dat0_i = 1'b1;

    sdc_cmd_engine #(.TICK_DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_stb(bit_stb),
        .cmd_o(cmd_o), .cmd_oe(cmd_oe), .cmd_i(cmd_i), .dat0_i(dat0_i)
    );

    always #10 clk = ~clk;

    int vecs = 0, fails = 0, cyc = 0;
    bit finished = 0;

    // card model state
    int           c_mode = 0, c_delay = 1, c_busy_n = 0;
    logic [135:0] c_resp = '0;
    logic [47:0]  c_sh = '0, c_last = '0;
    int           c_n = 0, c_frames = 0, c_state = 0, c_dcnt = 0, c_idx = 0, c_bcnt = 0;
    bit           c_idle = 1;
    int           c_release = 0;
    int           launch_cyc = 0, done_cyc = 0;

    initial forever begin @(posedge clk); cyc++; end

    function automatic logic [6:0] bcrc(input logic [39:0] d);
        logic [6:0] r = '0;
        for (int i = 39; i >= 0; i--) begin
            logic t;
            t = d[i] ^ r[6];
            r = {r[5:3], r[2] ^ t, r[1:0], t};
        end
        return r;
    endfunction

    function automatic logic [47:0] bframe(input logic [5:0] idx, input logic [31:0] arg);
        return {2'b01, idx, arg, bcrc({2'b01, idx, arg}), 1'b1};
    endfunction

    function automatic logic [47:0] bshort(input logic [5:0] idx, input logic [31:0] st);
        return {2'b00, idx, st, bcrc({2'b00, idx, st}), 1'b1};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] v;
        int n = 0;
        do begin rd(3'd0, v); n++; end while (v[15] && n < 20000);
        done_cyc = cyc;
        while (!c_idle) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic launch(input logic [15:0] cw, input logic [31:0] arg);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd1, arg);
        wr(3'd0, {16'b0, cw | 16'h8000});
        launch_cyc = cyc;
    endtask

    // card: acts once per bit tick, on the falling edge
    initial forever begin
        @(negedge clk);
        if (rst || !bit_stb) continue;
        case (c_state)
            0: begin
                cmd_i = 1'b1;
                if (cmd_oe) begin
                    c_sh = {c_sh[46:0], cmd_o};
                    c_n++;
                    if (c_n == 48) begin
                        c_n = 0; c_frames++; c_last = c_sh;
                        if (c_mode != 0) begin c_state = 1; c_dcnt = 0; c_idle = 0; end
                    end
                end
            end
            1: begin
                c_dcnt++;
                if (c_dcnt == c_delay) begin
                    c_idx = (c_mode == 2) ? 135 : 47;
                    cmd_i = c_resp[c_idx];
                    c_idx--;
                    c_state = 2;
                end
            end
            2: begin
                cmd_i = c_resp[c_idx];
                if (c_idx == 0) begin
                    if (c_busy_n > 0) begin dat0_i = 1'b0; c_bcnt = 0; c_state = 3; end
                    else begin c_state = 0; c_idle = 1; end
                end
                c_idx--;
            end
            default: begin
                cmd_i = 1'b1;
                c_bcnt++;
                if (c_bcnt >= c_busy_n) begin
                    dat0_i = 1'b1; c_release = cyc; c_state = 0; c_idle = 1;
                end
            end
        endcase
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, st, prev_w0;
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [127:0] pay;
        int f0;
        void'($urandom(32'h5D1C_0A7E));
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(3'd0, v); chk("R2 reset cmd word", v, 0);
        rd(3'd3, v); chk("R10 reset status", v, 0);
        rd(3'd2, v); chk("R6 reset timeout", v, 64);
        for (int i = 4; i < 8; i++) begin rd(3'(i), v); chk("R4 reset rsp", v, 0); end
        chk("R1 reset oe", cmd_oe, 0);

        wr(3'd2, TOUT);

        // short replies, random
        for (int k = 0; k < 12; k++) begin
            idx = 6'($urandom); arg = $urandom; st = $urandom;
            c_mode = 1; c_busy_n = 0; c_delay = 1 + int'($urandom % TOUT);
            c_resp = {88'b0, bshort(idx, st)};
            launch({10'b0, idx}, arg);
            wait_done();
            chk("R1 frame", c_last, bframe(idx, arg));
            rd(3'd4, v); chk("R4 word0", v, st);
            rd(3'd5, v); chk("R4 word1", v, 0);
            rd(3'd3, v); chk("R7 status clean", v, 0);
            rd(3'd0, v); chk("R2 start cleared", v[15:14], 0);
        end

        // long replies, random
        for (int k = 0; k < 6; k++) begin
            idx = 6'($urandom); arg = $urandom;
            pay = {$urandom, $urandom, $urandom, $urandom};
            c_mode = 2; c_delay = 1 + int'($urandom % TOUT);
            c_resp = {8'h3F, pay[127:1], 1'b1};
            launch(16'h0200 | {10'b0, idx}, arg);
            wait_done();
            for (int i = 0; i < 4; i++) begin
                rd(3'(4 + i), v);
                chk("R5 long word", v, (i == 0) ? {pay[31:1], 1'b1} : pay[32*i +: 32]);
            end
            rd(3'd3, v); chk("R5 no crc check", v, 0);
        end

        // timeout boundary
        idx = 6'd17; st = 32'hA5A5_0F0F;
        c_mode = 1; c_delay = TOUT; c_resp = {88'b0, bshort(idx, st)};
        launch({10'b0, idx}, 32'h1);
        wait_done();
        rd(3'd3, v); chk("R6 last sample accepted", v, 0);
        rd(3'd4, prev_w0); chk("R6 reply stored", prev_w0, st);
        c_delay = TOUT + 1; c_resp = {88'b0, bshort(idx, 32'h1234_5678)};
        launch({10'b0, idx}, 32'h2);
        wait_done();
        rd(3'd3, v); chk("R6 timeout bit", v, 32'h40);
        rd(3'd0, v); chk("R6 fail bit", v[14], 1);
        rd(3'd4, v); chk("R6 words kept", v, prev_w0);

        // write-one-to-clear
        wr(3'd3, 32'h0); rd(3'd3, v); chk("R10 zero keeps", v, 32'h40);
        wr(3'd3, 32'h10); rd(3'd3, v); chk("R10 other bit keeps", v, 32'h40);
        wr(3'd3, 32'h40); rd(3'd3, v); chk("R10 one clears", v, 0);

        // field readback and fail clear
        wr(3'd0, 32'h0000_0FD5); rd(3'd0, v); chk("R11 fields", v, 32'h0ED5);

        // bad CRC
        idx = 6'd3; st = 32'hDEAD_BEEF;
        c_mode = 1; c_delay = 2; c_resp = {88'b0, bshort(idx, st) ^ 48'h4};
        launch({10'b0, idx}, 32'h55);
        wait_done();
        rd(3'd3, v); chk("R7 crc bit", v, 32'h10);
        rd(3'd0, v); chk("R7 fail bit", v[14], 1);
        rd(3'd4, v); chk("R7 reply stored", v, st);

        // no reply, plain and with long bit
        for (int k = 0; k < 2; k++) begin
            c_mode = 0; f0 = c_frames;
            launch((k == 0) ? 16'h0400 : 16'h0600, 32'hC0DE_0000 + 32'(k));
            wait_done();
            chk("R8 one frame", c_frames - f0, 1);
            chk("R8 early done", (done_cyc - launch_cyc) <= 215 && (done_cyc - launch_cyc) >= 190, 1);
            rd(3'd3, v); chk("R8 no error", v, 0);
        end

        // busy wait after a short reply
        idx = 6'd7; st = 32'h0000_0900;
        c_mode = 1; c_delay = 3; c_busy_n = 10; c_resp = {88'b0, bshort(idx, st)};
        launch(16'h0800 | {10'b0, idx}, 32'h0);
        wait_done();
        rd(3'd3, v); chk("R9 busy done bit", v, 32'h400);
        chk("R9 waits for release", done_cyc > c_release, 1);

        // busy with long reply: busy ignored
        pay = {$urandom, $urandom, $urandom, $urandom};
        c_mode = 2; c_delay = 2; c_busy_n = 30; c_resp = {8'h3F, pay[127:1], 1'b1};
        launch(16'h0A00 | 16'd2, 32'h0);
        wait_done();
        rd(3'd3, v); chk("R9 long ignores busy", v, 0);
        chk("R9 done before release", done_cyc < c_release, 1);
        c_busy_n = 0;

        // command write while in flight
        idx = 6'd41; st = 32'h600D_F00D;
        c_mode = 1; c_delay = 4; c_resp = {88'b0, bshort(idx, st)}; f0 = c_frames;
        launch({10'b0, idx}, 32'hFACE_0001);
        rd(3'd0, v); chk("R2 start set in flight", v[15], 1);
        wr(3'd0, 32'h0000_8000 | 32'd9);
        wait_done();
        repeat (300) @(negedge clk);
        chk("R3 single frame", c_frames - f0, 1);
        chk("R3 frame kept", c_last, bframe(idx, 32'hFACE_0001));
        rd(3'd0, v); chk("R3 word unchanged", v[5:0], idx);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule